// File: doc/BRIEF.md
# UART Transmit/Receive FIFO Pair with DMA Ready Signalling

This block sits between a UART's shift registers and the host bus side. It holds one transmit queue and one receive queue. Each queue has its own push/pop port. A single byte-wide control write sets the queue depth, clears either queue and enables or disables queueing. The same write selects the receive threshold and the DMA handshake mode. The shift registers, baud generation, line status and interrupts live elsewhere. This block only reports occupancy, flags, a receive threshold condition and two DMA ready outputs.

With queueing disabled, each direction behaves as a one-byte holding register. With queueing enabled, the capacity is either a shallow depth (16) or a deep depth (64). The receive threshold comes from a two-bit code and a table that depends on the depth. In the simple handshake mode the ready outputs follow the empty flags directly. In the burst handshake mode they have hysteresis. The transmit ready output latches when the queue fills and releases only when the queue is drained. The receive ready output latches on the threshold or on an external time-out pulse, and releases only when the queue is empty.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset, both counts are 0, both empty flags are 1, the control readback is 0x00, `txrdy` is 0 and `rxrdy` is 1.
- R2: The capacity of each queue is 1 when control bit 0 (enable) is 0. It is 16 when bit 0 is 1 and bit 5 is 0, and 64 when bits 0 and 5 are both 1. A push made while the count equals the capacity is dropped and leaves the count unchanged. The full flag is 1 while the count equals the capacity.
- R3: Pops return bytes in push order. The popped byte appears on the read-data port in the cycle after the pop.
- R4: A pop from an empty queue leaves the read-data port at its previous value, and the count stays 0.
- R5: A control write with bit 1 set empties the receive queue in that cycle and leaves the transmit count unchanged. The readback at bit 1 is 0. The readback layout is bits 7:6 threshold code, bit 5 depth, bit 4 spare (stored as written, no effect), bit 3 burst mode, bits 2:1 always 0, bit 0 enable.
- R6: A control write with bit 2 set empties the transmit queue in that cycle and leaves the receive count unchanged.
- R7: A control write that changes bit 0 or bit 5 empties both queues in that cycle.
- R8: At depth 16, `rx_trig` is 1 when the receive count is at least the level for code bits 7:6. The levels are 1 for code 00, 4 for 01, 8 for 10 and 14 for 11.
- R9: At depth 64, the levels are 1 for 00, 16 for 01, 32 for 10 and 56 for 11. With the enable bit at 0, the level is 1 whatever the code.
- R10: Outside burst mode (bit 0 = 0 or bit 3 = 0), `txrdy` equals NOT the transmit empty flag. `rxrdy` equals the receive empty flag, and `rx_timeout` has no effect.
- R11: In burst mode (bits 0 and 3 both 1), `txrdy` goes to 1 when the transmit queue is full. It stays 1 while any entry remains and returns to 0 once the queue is empty.
- R12: In burst mode, `rxrdy` goes to 0 when the receive count reaches the level, or when `rx_timeout` is 1 while data is present. It stays 0 until the receive queue is empty, then returns to 1.
- R13: A receive push that is dropped because the queue is full gives a one-cycle pulse on `rx_overrun` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register readback |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_wdata | input | 8 | Transmit push data |
| tx_pop | input | 1 | Pop from the transmit queue (shift-register side) |
| tx_rdata | output | 8 | Last byte popped from the transmit queue |
| tx_count | output | 7 | Transmit occupancy |
| tx_full | output | 1 | Transmit queue at capacity |
| tx_empty | output | 1 | Transmit queue empty |
| rx_push | input | 1 | Push a received byte (shift-register side) |
| rx_wdata | input | 8 | Receive push data |
| rx_pop | input | 1 | Pop from the receive queue |
| rx_rdata | output | 8 | Last byte popped from the receive queue |
| rx_count | output | 7 | Receive occupancy |
| rx_full | output | 1 | Receive queue at capacity |
| rx_empty | output | 1 | Receive queue empty |
| rx_timeout | input | 1 | Receive time-out pulse |
| rx_trig | output | 1 | Receive count at or above the threshold |
| rx_overrun | output | 1 | One-cycle pulse on a dropped receive push |
| txrdy | output | 1 | Transmit DMA ready |
| rxrdy | output | 1 | Receive DMA ready |

## Verification
The assertions assume three things about the environment. Capacity changes happen only on the same edge as a flush. A time-out pulse matters only while received data is present. Reset is held low from time zero. The design guarantees the first, because any change of the enable or depth bit flushes both queues. The stimulus respects the other two: it raises the time-out only with a non-empty receive queue, and it never combines a clear with a push or pop. Inputs change only at falling edges, and each push, pop or control write lasts a single cycle.

// File: rtl/uart_fifo_pkg.sv
`timescale 1ns/1ps
// Shared types for the UART queue pair.
package uart_fifo_pkg;

    // Stored control fields; the command bits (clears) are not stored.
    typedef struct packed {
        logic [1:0] trig;   // receive threshold code
        logic       deep;   // 1 = deep depth, 0 = shallow depth
        logic       rsv;    // spare bit, stored only
        logic       dma;    // burst handshake mode
        logic       en;     // queueing enabled
    } fifo_cfg_t;

endpackage

// File: rtl/uart_fifo_ctl.sv
`timescale 1ns/1ps
// Control register for the queue pair.
// Stores the mode fields, turns bits 1 and 2 into one-cycle clear commands,
// and flushes both queues when the enable or depth bit changes.
// Assumes writes are single-cycle strobes.
module uart_fifo_ctl
    import uart_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output fifo_cfg_t  cfg,
    output logic       rx_clr,
    output logic       tx_clr,
    output logic [7:0] rdata
);

    logic regime_change;

    // Detect a write that alters the storage regime (enable or depth).
    always_comb begin
        regime_change = we && ((wdata[0] != cfg.en) || (wdata[5] != cfg.deep));
        rx_clr        = (we && wdata[1]) || regime_change;
        tx_clr        = (we && wdata[2]) || regime_change;
        rdata         = {cfg.trig, cfg.deep, cfg.rsv, cfg.dma, 2'b00, cfg.en};
    end

    // Capture the stored fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            cfg.trig <= wdata[7:6];
            cfg.deep <= wdata[5];
            cfg.rsv  <= wdata[4];
            cfg.dma  <= wdata[3];
            cfg.en   <= wdata[0];
        end
    end

    // R7: a regime change must flush both directions together.
    a_r7_flush_both: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (wdata[0] != cfg.en)) |-> (rx_clr && tx_clr));

endmodule

// File: rtl/uart_sync_fifo.sv
`timescale 1ns/1ps
// Single-clock queue with a run-time capacity limit.
// Storage is DEPTH entries; cap (1..DEPTH) limits occupancy. Pops register
// the head byte onto rdata; an empty pop leaves rdata alone. clr empties the
// queue on the edge it is seen and wins over a push.
// Assumes DEPTH is a power of two and cap changes only together with clr.
module uart_sync_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [CNT_W-1:0]  cap,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              do_push, do_pop;

    // Decode accepted operations against the current occupancy.
    always_comb begin
        full    = (count >= cap);
        empty   = (count == '0);
        do_push = push && !full && !clr;
        do_pop  = pop && !empty;
    end

    // Write the storage array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Advance pointers and occupancy; clear resets both.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // Register the popped byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (do_pop) rdata <= mem[rd_ptr];
    end

    // R2: occupancy never exceeds the selected capacity.
    a_r2_count_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
        count <= cap);

    // R2: with no operation the occupancy holds.
    a_r2_idle_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop && !clr) |=> $stable(count));

    // R5: a clear leaves the queue empty.
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    // R4: popping an empty queue keeps the output byte.
    a_r4_empty_pop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clr) |=> ($stable(rdata) && count == '0));

endmodule

// File: rtl/uart_ready_gen.sv
`timescale 1ns/1ps
// Receive threshold and DMA ready outputs.
// Simple mode: ready outputs follow the empty flags. Burst mode: transmit
// ready latches on full until empty; receive ready latches low on threshold
// or time-out until empty.
// Assumes rx_timeout is only meaningful while the receive queue holds data.
module uart_ready_gen
    import uart_fifo_pkg::*;
#(
    parameter int SHALLOW = 16,
    parameter int DEEP    = 64,
    localparam int CNT_W  = $clog2(DEEP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fifo_cfg_t        cfg,
    input  logic             tx_full,
    input  logic             tx_empty,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_empty,
    input  logic             rx_timeout,
    output logic             rx_trig,
    output logic             txrdy,
    output logic             rxrdy
);

    localparam logic [CNT_W-1:0] LV_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] LV_S1  = CNT_W'(SHALLOW / 4);
    localparam logic [CNT_W-1:0] LV_S2  = CNT_W'(SHALLOW / 2);
    localparam logic [CNT_W-1:0] LV_S3  = CNT_W'(SHALLOW - 2);
    localparam logic [CNT_W-1:0] LV_D1  = CNT_W'(DEEP / 4);
    localparam logic [CNT_W-1:0] LV_D2  = CNT_W'(DEEP / 2);
    localparam logic [CNT_W-1:0] LV_D3  = CNT_W'(DEEP - 8);

    logic [CNT_W-1:0] level;
    logic             burst;
    logic             tx_hold_q, rx_act_q;
    logic             tx_set, rx_set;

    // Pick the threshold from depth and code.
    always_comb begin
        if (!cfg.en) begin
            level = LV_ONE;
        end else begin
            case ({cfg.deep, cfg.trig})
                3'b001:  level = LV_S1;
                3'b010:  level = LV_S2;
                3'b011:  level = LV_S3;
                3'b101:  level = LV_D1;
                3'b110:  level = LV_D2;
                3'b111:  level = LV_D3;
                default: level = LV_ONE;
            endcase
        end
    end

    // Form the ready outputs from live flags plus the latched state.
    always_comb begin
        burst   = cfg.en && cfg.dma;
        rx_trig = (rx_count >= level);
        tx_set  = (tx_hold_q || tx_full) && !tx_empty;
        rx_set  = (rx_act_q || rx_trig || rx_timeout) && !rx_empty;
        txrdy   = burst ? tx_set  : !tx_empty;
        rxrdy   = burst ? !rx_set : rx_empty;
    end

    // Hold the hysteresis state while in burst mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hold_q <= 1'b0;
            rx_act_q  <= 1'b0;
        end else begin
            tx_hold_q <= burst && tx_set;
            rx_act_q  <= burst && rx_set;
        end
    end

    // R11: once asserted in burst mode, transmit ready holds until empty.
    a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (burst && $past(burst) && $past(txrdy) && !tx_empty) |-> txrdy);

    // R12: once dropped in burst mode, receive ready stays low until empty.
    a_r12_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (burst && $past(burst) && !$past(rxrdy) && !rx_empty) |-> !rxrdy);

    // R12: an empty receive queue always releases receive ready.
    a_r12_empty_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_empty && !rx_act_q) |-> rxrdy);

endmodule

// File: rtl/uart_fifo_pair.sv
`timescale 1ns/1ps
// Top level: transmit and receive queues for a UART, control register,
// threshold and DMA ready logic, and the receive overrun pulse.
// Assumes one clock domain and a synchronous active-low reset.
module uart_fifo_pair
    import uart_fifo_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int SHALLOW_DEPTH = 16,
    parameter int DEEP_DEPTH    = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ctl_we,
    input  logic [7:0]                       ctl_wdata,
    output logic [7:0]                       ctl_rdata,
    input  logic                             tx_push,
    input  logic [DATA_W-1:0]                tx_wdata,
    input  logic                             tx_pop,
    output logic [DATA_W-1:0]                tx_rdata,
    output logic [$clog2(DEEP_DEPTH+1)-1:0]  tx_count,
    output logic                             tx_full,
    output logic                             tx_empty,
    input  logic                             rx_push,
    input  logic [DATA_W-1:0]                rx_wdata,
    input  logic                             rx_pop,
    output logic [DATA_W-1:0]                rx_rdata,
    output logic [$clog2(DEEP_DEPTH+1)-1:0]  rx_count,
    output logic                             rx_full,
    output logic                             rx_empty,
    input  logic                             rx_timeout,
    output logic                             rx_trig,
    output logic                             rx_overrun,
    output logic                             txrdy,
    output logic                             rxrdy
);

    localparam int CNT_W = $clog2(DEEP_DEPTH + 1);

    fifo_cfg_t        cfg;
    logic             rx_clr, tx_clr;
    logic [CNT_W-1:0] cap;

    uart_fifo_ctl u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ctl_we),
        .wdata  (ctl_wdata),
        .cfg    (cfg),
        .rx_clr (rx_clr),
        .tx_clr (tx_clr),
        .rdata  (ctl_rdata)
    );

    // Capacity shared by both queues.
    always_comb begin
        if (!cfg.en)      cap = CNT_W'(1);
        else if (cfg.deep) cap = CNT_W'(DEEP_DEPTH);
        else               cap = CNT_W'(SHALLOW_DEPTH);
    end

    uart_sync_fifo #(.DATA_W(DATA_W), .DEPTH(DEEP_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tx_clr),
        .cap   (cap),
        .push  (tx_push),
        .wdata (tx_wdata),
        .pop   (tx_pop),
        .rdata (tx_rdata),
        .count (tx_count),
        .full  (tx_full),
        .empty (tx_empty)
    );

    uart_sync_fifo #(.DATA_W(DATA_W), .DEPTH(DEEP_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_clr),
        .cap   (cap),
        .push  (rx_push),
        .wdata (rx_wdata),
        .pop   (rx_pop),
        .rdata (rx_rdata),
        .count (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    uart_ready_gen #(.SHALLOW(SHALLOW_DEPTH), .DEEP(DEEP_DEPTH)) u_rdy (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .tx_full    (tx_full),
        .tx_empty   (tx_empty),
        .rx_count   (rx_count),
        .rx_empty   (rx_empty),
        .rx_timeout (rx_timeout),
        .rx_trig    (rx_trig),
        .txrdy      (txrdy),
        .rxrdy      (rxrdy)
    );

    // Flag a receive push that was dropped for lack of room.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_overrun <= 1'b0;
        else        rx_overrun <= rx_push && rx_full && !rx_clr;
    end

    // R13: an overrun pulse follows a push into a queue at capacity.
    a_r13_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> ($past(rx_push) && $past(rx_count) == $past(cap)));

endmodule

// File: tb/tb_uart_fifo_pair.sv
`timescale 1ns/1ps
// Directed bench for the UART queue pair.
module tb_uart_fifo_pair;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       tx_push = 1'b0, tx_pop = 1'b0;
    logic [7:0] tx_wdata = '0, tx_rdata;
    logic [6:0] tx_count, rx_count;
    logic       tx_full, tx_empty;
    logic       rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] rx_wdata = '0, rx_rdata;
    logic       rx_full, rx_empty;
    logic       rx_timeout = 1'b0;
    logic       rx_trig, rx_overrun, txrdy, rxrdy;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    uart_fifo_pair dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .tx_push(tx_push), .tx_wdata(tx_wdata),
        .tx_pop(tx_pop), .tx_rdata(tx_rdata), .tx_count(tx_count),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_push(rx_push),
        .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_count(rx_count), .rx_full(rx_full), .rx_empty(rx_empty),
        .rx_timeout(rx_timeout), .rx_trig(rx_trig), .rx_overrun(rx_overrun),
        .txrdy(txrdy), .rxrdy(rxrdy)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] d);
        @(negedge clk); tx_push = 1'b1; tx_wdata = d;
        @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic pop_tx();
        @(negedge clk); tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] d);
        @(negedge clk); rx_push = 1'b1; rx_wdata = d;
        @(negedge clk); rx_push = 1'b0;
    endtask

    task automatic pop_rx();
        @(negedge clk); rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask

    function automatic int exp_level(input bit deep, input int code);
        int s [4] = '{1, 4, 8, 14};
        int d [4] = '{1, 16, 32, 56};
        return deep ? d[code] : s[code];
    endfunction

    task automatic t_reset();
        check("R1", "tx_count", tx_count, 0);
        check("R1", "rx_count", rx_count, 0);
        check("R1", "tx_empty", tx_empty, 1);
        check("R1", "rx_empty", rx_empty, 1);
        check("R1", "ctl_rdata", ctl_rdata, 0);
        check("R1", "txrdy", txrdy, 0);
        check("R1", "rxrdy", rxrdy, 1);
    endtask

    task automatic t_disabled();
        push_tx(8'hA1);
        push_tx(8'hA2);
        check("R2", "disabled tx count", tx_count, 1);
        check("R2", "disabled tx full", tx_full, 1);
        check("R10", "txrdy with data", txrdy, 1);
        check("R10", "rxrdy empty", rxrdy, 1);
        push_rx(8'h11);
        check("R10", "rxrdy with data", rxrdy, 0);
        check("R9", "disabled level one", rx_trig, 1);
        pop_tx();
        check("R3", "disabled pop data", tx_rdata, 8'hA1);
        check("R10", "txrdy empty", txrdy, 0);
    endtask

    task automatic t_enable_flush();
        wr_ctl(8'h01);
        check("R7", "rx flushed by enable", rx_count, 0);
        check("R1", "readback enable", ctl_rdata, 8'h01);
    endtask

    task automatic t_order16();
        for (int i = 0; i < 20; i++) push_tx(8'(8'h30 + i));
        check("R2", "shallow tx count", tx_count, 16);
        check("R2", "shallow tx full", tx_full, 1);
        for (int i = 0; i < 16; i++) begin
            pop_tx();
            check("R3", "shallow pop order", tx_rdata, 8'h30 + i);
        end
        pop_tx();
        check("R4", "empty pop data", tx_rdata, 8'h3F);
        check("R4", "empty pop count", tx_count, 0);
    endtask

    task automatic t_trig(input bit deep);
        logic [7:0] base;
        base = deep ? 8'h21 : 8'h01;
        push_tx(8'h55);
        push_tx(8'h56);
        for (int c = 0; c < 4; c++) begin
            int lv;
            lv = exp_level(deep, c);
            wr_ctl(base | 8'(c << 6));
            for (int k = 0; k < lv - 1; k++) push_rx(8'(k));
            if (lv > 1) check(deep ? "R9" : "R8", "below level", rx_trig, 0);
            push_rx(8'hEE);
            check(deep ? "R9" : "R8", "at level", rx_trig, 1);
            check(deep ? "R9" : "R8", "count at level", rx_count, lv);
            wr_ctl(base | 8'(c << 6) | 8'h02);
            check("R5", "rx cleared", rx_count, 0);
            check("R5", "tx untouched", tx_count, 2);
            check("R5", "readback bit1 zero", ctl_rdata, base | 8'(c << 6));
        end
    endtask

    task automatic t_deep();
        wr_ctl(8'h21);
        check("R7", "tx flushed by depth", tx_count, 0);
        for (int i = 0; i < 3; i++) push_rx(8'(i));
        for (int i = 0; i < 70; i++) push_tx(8'(i));
        check("R2", "deep tx count", tx_count, 64);
        wr_ctl(8'h25);
        check("R6", "tx cleared", tx_count, 0);
        check("R6", "rx untouched", rx_count, 3);
        wr_ctl(8'h23);
        check("R5", "rx cleared deep", rx_count, 0);
    endtask

    task automatic t_tx_burst();
        wr_ctl(8'h29);
        push_tx(8'h01);
        check("R11", "not full yet", txrdy, 0);
        for (int i = 0; i < 63; i++) push_tx(8'(i));
        check("R11", "full sets", txrdy, 1);
        pop_tx();
        check("R11", "holds after pop", txrdy, 1);
        for (int i = 0; i < 62; i++) pop_tx();
        check("R11", "holds at one", txrdy, 1);
        pop_tx();
        check("R11", "empty releases", txrdy, 0);
        push_tx(8'h02);
        check("R11", "no set below full", txrdy, 0);
        pop_tx();
    endtask

    task automatic t_rx_burst();
        wr_ctl(8'h69);
        for (int i = 0; i < 15; i++) push_rx(8'(i));
        check("R12", "below level", rxrdy, 1);
        push_rx(8'h0F);
        check("R12", "level drops", rxrdy, 0);
        for (int i = 0; i < 15; i++) pop_rx();
        check("R12", "holds low", rxrdy, 0);
        pop_rx();
        check("R12", "empty releases", rxrdy, 1);
        push_rx(8'h77);
        check("R12", "one entry", rxrdy, 1);
        @(negedge clk); rx_timeout = 1'b1;
        @(negedge clk); rx_timeout = 1'b0;
        check("R12", "timeout latches", rxrdy, 0);
        pop_rx();
        check("R12", "timeout released", rxrdy, 1);
        wr_ctl(8'h61);
        push_rx(8'h78);
        @(negedge clk); rx_timeout = 1'b1;
        @(negedge clk); rx_timeout = 1'b0;
        check("R10", "timeout ignored", rxrdy, 0);
        pop_rx();
        check("R10", "rxrdy empty again", rxrdy, 1);
    endtask

    task automatic t_overrun();
        wr_ctl(8'h01);
        for (int i = 0; i < 16; i++) push_rx(8'(i));
        check("R13", "no pulse when fitting", rx_overrun, 0);
        push_rx(8'hFF);
        check("R13", "pulse on drop", rx_overrun, 1);
        check("R13", "count kept", rx_count, 16);
        @(negedge clk);
        check("R13", "pulse one cycle", rx_overrun, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_enable_flush();
        t_order16();
        t_trig(1'b0);
        t_deep();
        t_trig(1'b1);
        t_tx_burst();
        t_rx_burst();
        t_overrun();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule